// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local bus and a PCI host bridge. It compares each local-bus address against three outbound windows: two memory windows and one IO window. For each lookup it reports, one clock later, whether a window matched, which window it was, whether the target is the card bus or the main PCI bus, and the translated address. Software sets each window's base, size mask and remap word through a simple write port.

The window size is written as an inverted mask, so every window is a power of two in size, 32 KiB or larger, and aligned to its size. Memory windows take their target bus from a flag in the remap word. The single IO window can serve only one target at a time. A claim port records which target needs IO. The first claim fixes the owner and locks it. A later claim from the same target changes nothing. A later claim from the other target leaves the owner as it is and sets a sticky conflict flag.

Top module: `outwin_xlate`

## Requirements
- R1: A write to a base register keeps only address bits 31:15. Bits 14:0 of the written data are ignored.
- R2: The range register holds the inverse of (window size − 1) and keeps only bits 31:15. A window matches when (addr[31:15] & range) equals (base & range).
- R3: In the remap word, bit 0 enables the window. A window whose enable bit is clear never matches, and all windows are disabled after reset.
- R4: On a hit, out_addr bits 31:15 take the remap bits where the range bit is 1 and the address bits where it is 0. Bits 14:0 pass through from the lookup address. Remap bits 14:1, other than bit 2, are ignored.
- R5: When several windows match, the lowest window wins: memory 1 (out_win=0), then memory 2 (out_win=1), then IO (out_win=2).
- R6: A miss gives out_hit=0, out_win=0, out_card=0 and out_addr=0.
- R7: out_vld is lk_vld delayed by exactly one clock, and every result appears one clock after its lookup.
- R8: For a memory window, out_card is bit 2 of that window's remap word (1 = card bus).
- R9: For the IO window, out_card follows the IO owner (io_owner_card), not remap bit 2. After reset the owner is the main PCI bus (0) and is unlocked. A lookup in the same cycle as a claim sees the owner from before the claim.
- R10: The first claim, from either target, sets io_owner_card to the claimant and raises io_locked. io_locked stays high until reset.
- R11: Once the owner is locked, a claim from the same target has no effect. A claim from the other target leaves the owner unchanged and sets io_conflict, which stays set until reset.
- R12: During and after reset, out_vld, out_hit, io_locked and io_conflict are 0.
- R13: A write with cfg_win=3 or cfg_fld=3 changes no register. cfg_win selects 0 = memory 1, 1 = memory 2, 2 = IO. cfg_fld selects 0 = base, 1 = range, 2 = remap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 2 | Window select for the write |
| cfg_fld | input | 2 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| claim_vld | input | 1 | IO ownership claim strobe |
| claim_card | input | 1 | Claimant: 1 = card bus, 0 = main PCI bus |
| lk_vld | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Local-bus address to decode |
| out_vld | output | 1 | Result valid |
| out_hit | output | 1 | A window matched |
| out_win | output | 2 | Index of the winning window |
| out_card | output | 1 | Target is the card bus |
| out_addr | output | 32 | Translated address |
| io_owner_card | output | 1 | Current IO window owner |
| io_locked | output | 1 | IO owner has been fixed |
| io_conflict | output | 1 | The other target claimed IO after the lock |

## Verification
The overlap to watch is an ownership claim that arrives in the same cycle as a lookup that hits the IO window. The bench drives both strobes on one falling edge. It expects the result of that lookup to carry the old owner's target flag, and the next IO lookup to carry the new owner. Configuration writes placed just before lookups show that a write takes effect only for lookups issued after it.

// File: rtl/outwin_pkg.sv
package outwin_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_LSB = 15;
  localparam int UP_W     = ADDR_W - PAGE_LSB;
  localparam int NWIN     = 3;
  localparam int WIN_W    = 2;
  localparam int EN_BIT   = 0;
  localparam int CARD_BIT = 2;
  localparam int WIN_IO   = 2;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_RANGE = 2'd1,
    FLD_REMAP = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

  typedef struct packed {
    logic [UP_W-1:0] base;
    logic [UP_W-1:0] rng;
    logic [UP_W-1:0] rmp;
    logic            en;
    logic            card;
  } win_cfg_t;
endpackage

// File: rtl/outwin_regs.sv
module outwin_regs
  import outwin_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [WIN_W-1:0]       cfg_win,
  input  logic [1:0]             cfg_fld,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  output win_cfg_t [NWIN-1:0]    cfg_q
);
  fld_e fld;
  assign fld = fld_e'(cfg_fld);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic sel;
    assign sel = cfg_we && (cfg_win == WIN_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (sel) begin
        case (fld)
          FLD_BASE:  cfg_q[g].base <= cfg_wdata[ADDR_W-1:PAGE_LSB];
          FLD_RANGE: cfg_q[g].rng  <= cfg_wdata[ADDR_W-1:PAGE_LSB];
          FLD_REMAP: begin
            cfg_q[g].rmp  <= cfg_wdata[ADDR_W-1:PAGE_LSB];
            cfg_q[g].en   <= cfg_wdata[EN_BIT];
            cfg_q[g].card <= cfg_wdata[CARD_BIT];
          end
          default: ;
        endcase
      end
    end

    // R3
    en_reset_chk: assert property (@(posedge clk) rst |=> !cfg_q[g].en);
  end
endmodule

// File: rtl/outwin_iosel.sv
module outwin_iosel (
  input  logic clk,
  input  logic rst,
  input  logic claim_vld,
  input  logic claim_card,
  output logic owner_card,
  output logic locked,
  output logic conflict
);
  always_ff @(posedge clk) begin
    if (rst) begin
      owner_card <= 1'b0;
      locked     <= 1'b0;
      conflict   <= 1'b0;
    end else if (claim_vld) begin
      if (!locked) begin
        locked     <= 1'b1;
        owner_card <= claim_card;
      end else if (claim_card != owner_card) begin
        conflict <= 1'b1;
      end
    end
  end

  // R10
  first_claim_chk: assert property (@(posedge clk) disable iff (rst)
    (claim_vld && !locked) |=> (locked && owner_card == $past(claim_card)));
  // R10
  owner_lock_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && $stable(owner_card)));
  // R11
  conflict_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    conflict |=> conflict);
  // R11
  conflict_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conflict) |-> ($past(claim_vld) && $past(locked)));
endmodule

// File: rtl/outwin_match.sv
module outwin_match
  import outwin_pkg::*;
(
  input  logic [UP_W-1:0] addr_up,
  input  win_cfg_t        cfg,
  output logic            hit,
  output logic [UP_W-1:0] xlat_up
);
  always_comb begin
    hit     = cfg.en && ((addr_up & cfg.rng) == (cfg.base & cfg.rng));
    xlat_up = (cfg.rmp & cfg.rng) | (addr_up & ~cfg.rng);
  end
endmodule

// File: rtl/outwin_xlate.sv
module outwin_xlate
  import outwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_win,
  input  logic [1:0]        cfg_fld,
  input  logic [31:0]       cfg_wdata,
  input  logic              claim_vld,
  input  logic              claim_card,
  input  logic              lk_vld,
  input  logic [31:0]       lk_addr,
  output logic              out_vld,
  output logic              out_hit,
  output logic [1:0]        out_win,
  output logic              out_card,
  output logic [31:0]       out_addr,
  output logic              io_owner_card,
  output logic              io_locked,
  output logic              io_conflict
);
  win_cfg_t [NWIN-1:0] cfg_q;
  logic [NWIN-1:0]     hit_v;
  logic [UP_W-1:0]     xl_v [NWIN];
  logic [NWIN-1:0]     card_v;

  outwin_regs u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  outwin_iosel u_iosel (
    .clk(clk), .rst(rst), .claim_vld(claim_vld), .claim_card(claim_card),
    .owner_card(io_owner_card), .locked(io_locked), .conflict(io_conflict)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_m
    outwin_match u_m (
      .addr_up(lk_addr[ADDR_W-1:PAGE_LSB]), .cfg(cfg_q[g]),
      .hit(hit_v[g]), .xlat_up(xl_v[g])
    );
    if (g == WIN_IO) begin : g_io
      assign card_v[g] = io_owner_card;
    end else begin : g_mem
      assign card_v[g] = cfg_q[g].card;
    end
  end

  logic              sel_hit;
  logic [WIN_W-1:0]  sel_win;
  logic              sel_card;
  logic [ADDR_W-1:0] sel_addr;

  always_comb begin
    sel_hit  = 1'b0;
    sel_win  = '0;
    sel_card = 1'b0;
    sel_addr = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (!sel_hit && hit_v[i]) begin
        sel_hit  = 1'b1;
        sel_win  = WIN_W'(i);
        sel_card = card_v[i];
        sel_addr = {xl_v[i], lk_addr[PAGE_LSB-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_hit  <= 1'b0;
      out_win  <= '0;
      out_card <= 1'b0;
      out_addr <= '0;
    end else begin
      out_vld  <= lk_vld;
      out_hit  <= lk_vld && sel_hit;
      out_win  <= lk_vld ? sel_win  : '0;
      out_card <= lk_vld ? sel_card : 1'b0;
      out_addr <= lk_vld ? sel_addr : '0;
    end
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld == $past(lk_vld));
  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_hit) |-> (out_addr == '0 && !out_card && out_win == '0));
  // R4
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_addr[PAGE_LSB-1:0] == $past(lk_addr[PAGE_LSB-1:0]));
  // R9
  io_card_chk: assert property (@(posedge clk) disable iff (rst)
    (out_hit && out_win == WIN_W'(WIN_IO)) |-> out_card == $past(io_owner_card));
  // R5
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_win < WIN_W'(NWIN));
endmodule

// File: tb/sim_outwin_xlate.sv
module sim_outwin_xlate;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic        hit;
    logic [1:0]  win;
    logic        card;
    logic [31:0] addr;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [1:0] cfg_win = 0, cfg_fld = 0; logic [31:0] cfg_wdata = 0;
  logic claim_vld = 0, claim_card = 0, lk_vld = 0; logic [31:0] lk_addr = 0;
  logic out_vld, out_hit, out_card, io_owner_card, io_locked, io_conflict;
  logic [1:0] out_win; logic [31:0] out_addr;

  int checks = 0, errors = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  logic [16:0] sb[3], sr[3], sm[3];
  logic se[3], sc[3];
  logic sown, slock, sconf;

  always #(CLK_NS/2) clk = ~clk;

  outwin_xlate u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .claim_vld(claim_vld), .claim_card(claim_card),
    .lk_vld(lk_vld), .lk_addr(lk_addr), .out_vld(out_vld), .out_hit(out_hit),
    .out_win(out_win), .out_card(out_card), .out_addr(out_addr),
    .io_owner_card(io_owner_card), .io_locked(io_locked), .io_conflict(io_conflict)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a);
    exp_t e = '0;
    for (int i = 0; i < 3; i++) begin
      if (!e.hit && se[i] && ((a[31:15] & sr[i]) == (sb[i] & sr[i]))) begin
        e.hit  = 1'b1;
        e.win  = 2'(i);
        e.card = (i == 2) ? sown : sc[i];
        e.addr = {(sm[i] & sr[i]) | (a[31:15] & ~sr[i]), a[14:0]};
      end
    end
    return e;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      sb[i] = '0; sr[i] = '0; sm[i] = '0; se[i] = 0; sc[i] = 0;
    end
    sown = 0; slock = 0; sconf = 0;
  endtask

  task automatic cfg_wr(input logic [1:0] w, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_win = w; cfg_fld = f; cfg_wdata = d;
    if (w != 2'd3) begin
      if (f == 2'd0) sb[w] = d[31:15];
      else if (f == 2'd1) sr[w] = d[31:15];
      else if (f == 2'd2) begin sm[w] = d[31:15]; se[w] = d[0]; sc[w] = d[2]; end
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic model_claim(input logic c);
    if (!slock) begin slock = 1; sown = c; end
    else if (c != sown) sconf = 1;
  endtask

  task automatic drive_lookup(input logic [31:0] a, input string req);
    exp_q.push_back(model(a));
    tag_q.push_back(req);
    lk_vld = 1; lk_addr = a;
  endtask

  task automatic lookup(input logic [31:0] a, input string req);
    @(negedge clk);
    drive_lookup(a, req);
    @(negedge clk);
    lk_vld = 0;
  endtask

  task automatic claim(input logic c);
    @(negedge clk);
    claim_vld = 1; claim_card = c; model_claim(c);
    @(negedge clk);
    claim_vld = 0;
  endtask

  task automatic check_io(input string req);
    chk({req, " owner"},    32'(io_owner_card), 32'(sown));
    chk({req, " locked"},   32'(io_locked),     32'(slock));
    chk({req, " conflict"}, 32'(io_conflict),   32'(sconf));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=unexpected result expected=no result");
      end else begin
        exp_t e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk({t, " hit"},  32'(out_hit),  32'(e.hit));
        chk({t, " win"},  32'(out_win),  32'(e.win));
        chk({t, " card"}, 32'(out_card), 32'(e.card));
        chk({t, " addr"}, out_addr,      e.addr);
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 out_vld", 32'(out_vld), 0);
    chk("R12 out_hit", 32'(out_hit), 0);
    check_io("R12 R9");
    rst = 0;
    lookup(32'h1000_0000, "R3 R6 all disabled");

    // memory window 1, junk low bits
    cfg_wr(0, 0, 32'h1000_1234);              // R1
    cfg_wr(0, 1, 32'hFFF0_0000);              // 1 MiB
    cfg_wr(0, 2, 32'h8000_7FF9);              // R4 junk bits, en, card 0
    lookup(32'h1003_4567, "R1 R2 R4");
    lookup(32'h1010_0000, "R2 R6 outside");

    // memory window 2, card bus, 32 KiB
    cfg_wr(1, 0, 32'h2000_0000);
    cfg_wr(1, 1, 32'hFFFF_8FFF);              // R2 low bits ignored
    cfg_wr(1, 2, 32'h0004_0005);
    lookup(32'h2000_7ABC, "R8 R2");
    lookup(32'h2000_8000, "R2 R6 edge");

    // IO window; remap bit 2 must not set card
    cfg_wr(2, 0, 32'h3000_0000);
    cfg_wr(2, 1, 32'hFFFF_0000);
    cfg_wr(2, 2, 32'h0050_0005);
    lookup(32'h3000_F00D, "R9 io owner main");

    // R13 ignored writes
    cfg_wr(3, 0, 32'h0000_0000);
    cfg_wr(0, 3, 32'h0000_0000);
    lookup(32'h1003_4567, "R13 after ignored writes");

    // R5 priority with all three overlapping
    cfg_wr(1, 0, 32'h1000_0000);
    cfg_wr(2, 0, 32'h1000_0000);
    lookup(32'h1000_0010, "R5 mem1 first");
    cfg_wr(0, 2, 32'h8000_0000);              // R3 disable mem1
    lookup(32'h1000_0010, "R5 R3 mem2 next");
    cfg_wr(1, 2, 32'h0004_0004);
    lookup(32'h1000_0010, "R5 R3 io last");

    // R9 collision: claim and IO lookup same cycle
    @(negedge clk);
    drive_lookup(32'h1000_0020, "R9 same-cycle claim");
    claim_vld = 1; claim_card = 1;
    model_claim(1'b1);
    @(negedge clk);
    lk_vld = 0; claim_vld = 0;
    check_io("R10 first claim card");
    lookup(32'h1000_0020, "R9 new owner");

    // R11
    claim(1'b1);
    check_io("R11 same owner ignored");
    claim(1'b0);
    check_io("R11 conflict");
    claim(1'b0);
    check_io("R11 sticky owner");
    lookup(32'h1000_0030, "R11 owner kept");

    // R7 idle
    @(negedge clk);
    chk("R7 idle out_vld", 32'(out_vld), 0);

    // second reset: first claim by main bus locks it
    @(negedge clk); rst = 1; model_reset();
    @(negedge clk); @(negedge clk);
    check_io("R12 after reset");
    rst = 0;
    claim(1'b0);
    check_io("R10 first claim main");
    claim(1'b1);
    check_io("R11 card after main lock");
    lookup(32'h1000_0000, "R3 disabled after reset");

    repeat (4) @(negedge clk);
    chk("R7 drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule